// File: doc/BRIEF.md
# Serial Power-Mode Command Decoder

This block is the control port of a dual-channel transceiver front end. A host writes one command byte over a three-wire, write-only serial link made of an active-low select, a serial clock and a data line. The block frames the byte. If the frame is well formed, it turns the byte into one of six power modes. Each mode drives a fixed set of enables: the voltage reference, the receive converters, the transmit converters and the output driver of the receive data bus. A status field reports the code of the mode now in force.

All three serial inputs are oversampled by the block's own system clock. Each input passes through a synchroniser before edge detection. Only the three least significant bits of the byte select the mode, and the five bits above them are ignored. A frame changes the mode only when the select line is released after exactly eight data bits, and only when the code it carries is one of the six defined codes. In every other case the previous mode is kept.

Top module: `mode_cmd_slave`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters shutdown: all four enables are 0 and `mode_code` is 000.
- R2: A data bit is taken at each rising `sclk` edge while `cs_n` is low, most significant bit first. Only the last three bits of the frame (byte bits [2:0]) select the mode, and bits [7:3] have no effect.
- R3: A frame commits only if exactly 8 rising `sclk` edges occurred while `cs_n` was low. With 7 or 9 edges, the outputs keep their previous values.
- R4: Rising `sclk` edges while `cs_n` is high are ignored and do not count toward the next frame.
- R5: Code 000 (shutdown): `ref_en`=0, `rx_en`=0, `tx_en`=0, `rxbus_oe`=0.
- R6: Codes 001 (idle) and 101 (standby): `ref_en`=1, and the other three enables are 0. `mode_code` reports 001 or 101 respectively.
- R7: Code 010 (receive): `ref_en`=1, `rx_en`=1, `tx_en`=0, `rxbus_oe`=1.
- R8: Code 011 (transmit): `ref_en`=1, `rx_en`=0, `tx_en`=1, `rxbus_oe`=0.
- R9: Code 100 (transceive): all four enables are 1.
- R10: Codes 110 and 111 are ignored, and the previous mode and enables are kept.
- R11: The outputs change only when a valid frame commits. The new mode appears within SYNC_STAGES+2 clock cycles of `cs_n` rising, and the outputs are stable while a frame is in progress.
- R12: A rising `sclk` that is sampled in the same clock cycle as the rising `cs_n` is not counted as a data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data, MSB first |
| ref_en | output | 1 | Reference enable |
| rx_en | output | 1 | Receive converters enable |
| tx_en | output | 1 | Transmit converters enable |
| rxbus_oe | output | 1 | Receive data bus output enable |
| mode_code | output | 3 | Code of the mode in force |

## Verification
The end of a frame and the sampling of one more data bit can fall in the same synchronised clock cycle. The bench provokes this by driving `sclk` high and `cs_n` high in the same instant, both after seven bits and after eight. A frame with seven bits plus the colliding edge must be rejected. A frame with eight bits plus the colliding edge must commit its code. The bench mixes these collisions into random frames with random byte values, random upper bits and random bit counts, and predicts each result from a bench model of the mode table.

// File: rtl/mcd_pkg.sv
// Package: shared mode encoding and the mode-to-enable mapping.
// Assumes a 3-bit mode code; codes above 5 are not modes.
package mcd_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF    = 3'd0,
        MODE_IDLE   = 3'd1,
        MODE_RECV   = 3'd2,
        MODE_XMIT   = 3'd3,
        MODE_DUPLEX = 3'd4,
        MODE_STBY   = 3'd5
    } pwr_mode_e;

    typedef struct packed {
        logic ref_on;
        logic rx_on;
        logic tx_on;
        logic bus_drive;
    } enables_t;

    // True when a received code names a defined mode.
    function automatic logic code_valid(input logic [MODE_W-1:0] c);
        return (c <= 3'd5);
    endfunction

    // Fixed enable set for each mode.
    function automatic enables_t mode_enables(input pwr_mode_e m);
        enables_t e;
        e = '0;
        case (m)
            MODE_OFF:    e = '0;
            MODE_IDLE,
            MODE_STBY:   e.ref_on = 1'b1;
            MODE_RECV:   begin e.ref_on = 1'b1; e.rx_on = 1'b1; e.bus_drive = 1'b1; end
            MODE_XMIT:   begin e.ref_on = 1'b1; e.tx_on = 1'b1; end
            MODE_DUPLEX: begin e.ref_on = 1'b1; e.rx_on = 1'b1;
                               e.tx_on = 1'b1;  e.bus_drive = 1'b1; end
            default:     e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/mcd_sync.sv
// Module: multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes STAGES >= 1; each bit is sampled independently, reset to RST_VAL.
module mcd_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First flop captures the raw input.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= d;
            end
        end else begin : g_next
            // Later flops re-time the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/mcd_serial_rx.sv
// Module: frames a write-only serial command.
// Bits are taken on synchronised rising sclk while select is low, MSB first.
// Only the last MODE_W bits are kept. A one-cycle strobe is issued on the select
// release if exactly CMD_BITS bits arrived. An sclk rise seen in the same cycle
// as the select release is not counted.
module mcd_serial_rx #(
    parameter int CMD_BITS    = 8,
    parameter int MODE_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic [MODE_W-1:0] cmd_code,
    output logic              cmd_strobe
);

    localparam int SAT   = CMD_BITS + 1;
    localparam int CNT_W = $clog2(SAT + 1);

    logic [2:0]        sync_q;
    logic              cs_s, sck_s, sd_s;
    logic              cs_d, sck_d;
    logic              sck_rise, cs_rise;
    logic [CNT_W-1:0]  cnt_q;
    logic [MODE_W-1:0] shreg_q;

    mcd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sclk, sdi}),
        .q     (sync_q)
    );

    assign {cs_s, sck_s, sd_s} = sync_q;
    assign sck_rise = sck_s & ~sck_d;
    assign cs_rise  = cs_s & ~cs_d;

    // Edge history, bit counting and shifting of the trailing code bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d    <= 1'b1;
            sck_d   <= 1'b0;
            cnt_q   <= '0;
            shreg_q <= '0;
        end else begin
            cs_d  <= cs_s;
            sck_d <= sck_s;
            if (cs_s) begin
                cnt_q <= '0;
            end else if (sck_rise) begin
                shreg_q <= {shreg_q[MODE_W-2:0], sd_s};
                if (cnt_q != CNT_W'(SAT)) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign cmd_code   = shreg_q;
    assign cmd_strobe = cs_rise && (cnt_q == CNT_W'(CMD_BITS));

    // R3: at most one commit strobe per select release
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |=> !cmd_strobe);

    // R4: while select stays high no bit is counted
    idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && cs_d) |=> (cnt_q == '0));

endmodule

// File: rtl/mcd_mode_reg.sv
// Module: holds the active power mode and maps it to enables.
// Assumes cmd_strobe is a single-cycle pulse; invalid codes keep the mode.
module mcd_mode_reg
    import mcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] cmd_code,
    input  logic              cmd_strobe,
    output pwr_mode_e         mode,
    output enables_t          en
);

    pwr_mode_e mode_q;

    // Load a new mode on a valid committed code; shutdown after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_OFF;
        else if (cmd_strobe && code_valid(cmd_code))
            mode_q <= pwr_mode_e'(cmd_code);
    end

    assign mode = mode_q;
    assign en   = mode_enables(mode_q);

    // R11: mode holds when no frame commits
    hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_strobe |=> $stable(mode_q));

    // R10: undefined codes leave the mode unchanged
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe && cmd_code[2] && cmd_code[1]) |=> $stable(mode_q));

    // R2: a committed valid code becomes the mode on the next cycle
    load_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe && code_valid(cmd_code)) |=> (mode_q == $past(cmd_code)));

endmodule

// File: rtl/mode_cmd_slave.sv
// Module: top of the serial power-mode command decoder.
// Frames the command on the oversampled serial port and drives the mode
// enables. Assumes clk is several times faster than sclk.
module mode_cmd_slave #(
    parameter int CMD_BITS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       sdi,
    output logic       ref_en,
    output logic       rx_en,
    output logic       tx_en,
    output logic       rxbus_oe,
    output logic [2:0] mode_code
);
    import mcd_pkg::*;

    logic [MODE_W-1:0] cmd_code;
    logic              cmd_strobe;
    pwr_mode_e         mode;
    enables_t          en;

    mcd_serial_rx #(
        .CMD_BITS    (CMD_BITS),
        .MODE_W      (MODE_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .sdi        (sdi),
        .cmd_code   (cmd_code),
        .cmd_strobe (cmd_strobe)
    );

    mcd_mode_reg u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_code   (cmd_code),
        .cmd_strobe (cmd_strobe),
        .mode       (mode),
        .en         (en)
    );

    assign ref_en    = en.ref_on;
    assign rx_en     = en.rx_on;
    assign tx_en     = en.tx_on;
    assign rxbus_oe  = en.bus_drive;
    assign mode_code = mode;

    // R10: the status never shows an undefined code
    valid_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_code <= 3'd5);

    // R7: the receive bus is driven only with the receive converters on
    bus_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rxbus_oe |-> rx_en);

endmodule

// File: tb/mode_cmd_slave_bench.sv
// Bench: random and directed frames against a model of the mode table.
module mode_cmd_slave_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic       ref_en, rx_en, tx_en, rxbus_oe;
    logic [2:0] mode_code;

    int checks = 0;
    int errors = 0;
    int exp_mode = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mode_cmd_slave u_mode_cmd_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .ref_en    (ref_en),
        .rx_en     (rx_en),
        .tx_en     (tx_en),
        .rxbus_oe  (rxbus_oe),
        .mode_code (mode_code)
    );

    // Expected {ref, rx, tx, oe, code} for a mode code.
    function automatic logic [6:0] exp_vec(input int code);
        case (code)
            0:       return {4'b0000, 3'd0};
            1:       return {4'b1000, 3'd1};
            2:       return {4'b1101, 3'd2};
            3:       return {4'b1010, 3'd3};
            4:       return {4'b1111, 3'd4};
            5:       return {4'b1000, 3'd5};
            default: return 7'bx;
        endcase
    endfunction

    function automatic string code_tag(input int code);
        case (code)
            0:       return "R5";
            1, 5:    return "R6";
            2:       return "R7";
            3:       return "R8";
            4:       return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string tag);
        logic [6:0] got, exp;
        got = {ref_en, rx_en, tx_en, rxbus_oe, mode_code};
        exp = exp_vec(exp_mode);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame: nbits clocked bits, optional sclk rise together with cs release.
    task automatic send(input logic [7:0] b, input int nbits, input bit collide,
                        input string tag);
        cs_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < nbits; i++) begin
            sdi  = (i < 8) ? b[7-i] : 1'b0;
            sclk = 1'b0;
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(4);
        end
        sclk = 1'b0;
        if (nbits < 8) sdi = b[7-nbits];
        wait_clk(4);
        chk("R11");
        if (collide) sclk = 1'b1;
        cs_n = 1'b1;
        wait_clk(8);
        sclk = 1'b0;
        wait_clk(2);
        if (nbits == 8 && b[2:0] <= 3'd5) exp_mode = int'(b[2:0]);
        chk(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        wait_clk(5);
        exp_mode = 0;
        chk("R1");
        rst_n = 1'b1;
        wait_clk(3);
        chk("R1");

        // R2: MSB first, upper bits ignored
        send(8'hF9, 8, 1'b0, "R2");
        send(8'h20, 8, 1'b0, "R2");
        send(8'h04, 8, 1'b0, "R9");
        // R10: undefined codes keep transceive
        send(8'h06, 8, 1'b0, "R10");
        send(8'hFF, 8, 1'b0, "R10");
        // R3: short and long frames rejected
        send(8'h02, 7, 1'b0, "R3");
        send(8'h02, 9, 1'b0, "R3");
        send(8'h03, 8, 1'b0, "R8");
        // R4: sclk activity with select high is ignored
        for (int i = 0; i < 10; i++) begin
            sdi = i[0];
            sclk = 1'b1; wait_clk(4);
            sclk = 1'b0; wait_clk(4);
        end
        chk("R4");
        send(8'h02, 8, 1'b0, "R4");
        // R12: colliding edge not counted
        send(8'h05, 7, 1'b1, "R12");
        send(8'h05, 8, 1'b1, "R12");
        send(8'hAB, 8, 1'b0, "R8");
        send(8'h00, 8, 1'b0, "R5");

        for (int k = 0; k < 80; k++) begin
            logic [7:0] b;
            int r, n;
            bit col;
            b   = 8'($urandom);
            r   = int'($urandom % 5);
            n   = (r == 0) ? 7 : (r == 4) ? 9 : 8;
            col = ($urandom % 4) == 0;
            send(b, n, col, (n != 8) ? "R3" : code_tag(int'(b[2:0])));
        end

        // R1: reset from transceive returns to shutdown
        send(8'h04, 8, 1'b0, "R9");
        rst_n = 1'b0;
        wait_clk(2);
        exp_mode = 0;
        chk("R1");
        rst_n = 1'b1;
        wait_clk(2);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule